// File: doc/BRIEF.md
# Edge-Selectable Interrupt and Wake Controller

This block takes one external interrupt pin and turns a chosen edge on it into a sticky pending flag. Software picks the active edge, either rising or falling. The flag is always latched, whatever the enable bits say. From that flag and two enable bits, the block decides whether the core should branch to its interrupt vector.

The block also covers sleep. While the core sleeps with its clock possibly stopped, an asynchronous capture element records the chosen edge. It then raises a wake request with no clock edge needed. Two conditions are required: the core is asleep, and the source enable was already set when the core went to sleep.

After the core leaves sleep, the vector branch stays blocked until the core reports that the instruction after the sleep instruction has retired. If the global enable is clear, the core simply carries on and no branch is requested. The edge-select and enable bits are registered inside the block, so each takes effect one clock after it is presented.

Top module: `extint_wake_ctrl`

## Requirements
- R1: After reset the pending flag, wake request and vector request are all 0, the registered enables are 0 and rising edges are selected.
- R2: With edge select 1 only a 0-to-1 pin change is a valid event; with edge select 0 only a 1-to-0 change is. The opposite change leaves the pending flag unchanged. A new edge select value is used from the clock after it is presented.
- R3: With the clock running, a valid pin change sets the pending flag on the third rising clock edge after the change, whatever the enable bits are.
- R4: Once set, the pending flag stays 1 until the clear strobe is sampled high at a clock edge; it then reads 0 after that edge.
- R5: If a valid event and the clear strobe land on the same clock edge, the pending flag ends up 1.
- R6: Outside sleep and the post-wake window, the vector request is 1 exactly when the pending flag, the registered source enable and the registered global enable are all 1.
- R7: While asleep, if the source enable was 1 when sleep was entered, the wake request goes to 1 combinationally on a valid pin change, even with the clock stopped. It is also 1 when the flag was already pending at sleep entry.
- R8: Setting the source enable only after sleep has been entered never raises the wake request, but a valid edge still sets the pending flag.
- R9: After the sleep indication drops, the vector request stays 0 until the retire strobe is sampled high. It may rise on the next clock, and only if the global enable is 1.
- R10: The wake request falls to 0 one clock after the sleep indication drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, may be stopped during sleep |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_pin_i | input | 1 | Asynchronous external interrupt pin |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| src_en_i | input | 1 | Source enable for this interrupt |
| gie_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Core is in sleep |
| flag_clr_i | input | 1 | Clear strobe for the pending flag |
| retire_i | input | 1 | Instruction after the sleep instruction has retired |
| pending_o | output | 1 | Latched pending flag |
| wake_o | output | 1 | Wake request to the clock controller |
| vector_o | output | 1 | Request to branch to the interrupt vector |

## Verification
Setting the flag from an edge and clearing it from software can happen on the same clock edge. The bench provokes this by raising the pin, waiting two clocks, and then pulsing the clear strobe so that it is sampled on exactly the edge that latches the event. It then expects the flag still set on that edge and on the one after. A second overlap is between the retire strobe and the vector gate. The bench raises retire in the last post-wake cycle and expects no vector request during that cycle, then a request on the very next clock.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_POST  = 2'd2
  } seq_state_t;

  // a valid event: level moved in the selected direction
  function automatic logic edge_hit(input logic now_v, input logic was_v,
                                    input logic rise_sel);
    return rise_sel ? (now_v & ~was_v) : (~now_v & was_v);
  endfunction

  // sticky flag, a set beats a clear
  function automatic logic flag_next(input logic cur, input logic set_v,
                                     input logic clr_v);
    if (set_v) return 1'b1;
    if (clr_v) return 1'b0;
    return cur;
  endfunction

  function automatic seq_state_t seq_next(input seq_state_t cur,
                                          input logic slp, input logic ret);
    case (cur)
      ST_RUN:   return slp ? ST_SLEEP : ST_RUN;
      ST_SLEEP: return slp ? ST_SLEEP : ST_POST;
      ST_POST:  return ret ? ST_RUN : ST_POST;
      default:  return ST_RUN;
    endcase
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/extint_capture.sv
module extint_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  input  logic arm_i,
  output logic evt_o,
  output logic pend_o
);
  logic pin_eff;
  logic tog_a;
  logic tog_s;
  logic seen_q;

  // the selected edge becomes a rising edge of pin_eff
  assign pin_eff = rise_sel_i ? pin_i : ~pin_i;

  // clocked by the pin itself: works while the core clock is stopped
  always_ff @(posedge pin_eff or negedge rst_ni) begin
    if (!rst_ni)    tog_a <= 1'b0;
    else if (arm_i) tog_a <= ~tog_a;
  end

  extint_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tog_a),
    .q_o   (tog_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= tog_s;
  end

  assign evt_o  = tog_s ^ seen_q;
  assign pend_o = tog_a ^ seen_q;
endmodule

// File: rtl/extint_seq.sv
module extint_seq
  import extint_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       retire_i,
  input  logic       en_i,
  output seq_state_t state_o,
  output logic       en_snap_o
);
  seq_state_t state_q;
  logic       snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      snap_q  <= 1'b0;
    end else begin
      state_q <= seq_next(state_q, sleep_i, retire_i);
      if (state_q == ST_RUN && sleep_i) snap_q <= en_i;
    end
  end

  assign state_o   = state_q;
  assign en_snap_o = snap_q;
endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl
  import extint_pkg::*;
#(
  parameter int   SYNC_STAGES  = 2,
  parameter logic RST_EDGE_RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_pin_i,
  input  logic edge_rise_i,
  input  logic src_en_i,
  input  logic gie_i,
  input  logic sleep_i,
  input  logic flag_clr_i,
  input  logic retire_i,
  output logic pending_o,
  output logic wake_o,
  output logic vector_o
);
  logic       rise_q, en_q, gie_q;
  logic       pin_s, pin_prev_q;
  logic       sync_edge, cap_evt, cap_pend, set_evt;
  logic       flag_q;
  logic       en_snap, arm, sleeping, in_hold;
  seq_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= RST_EDGE_RISE;
      en_q   <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      rise_q <= edge_rise_i;
      en_q   <= src_en_i;
      gie_q  <= gie_i;
    end
  end

  extint_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (int_pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_q <= 1'b0;
    else         pin_prev_q <= pin_s;
  end

  assign sync_edge = edge_hit(pin_s, pin_prev_q, rise_q);

  extint_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .retire_i (retire_i),
    .en_i     (en_q),
    .state_o  (state_q),
    .en_snap_o(en_snap)
  );

  assign sleeping = (state_q == ST_SLEEP);
  assign in_hold  = (state_q != ST_RUN);
  assign arm      = sleeping & en_snap;

  extint_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (int_pin_i),
    .rise_sel_i(rise_q),
    .arm_i     (arm),
    .evt_o     (cap_evt),
    .pend_o    (cap_pend)
  );

  assign set_evt = sync_edge | cap_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_next(flag_q, set_evt, flag_clr_i);
  end

  assign pending_o = flag_q;
  assign wake_o    = arm & (flag_q | cap_pend);
  assign vector_o  = flag_q & en_q & gie_q & ~in_hold;
endmodule

// File: rtl/extint_wake_chk.sv
module extint_wake_chk
  import extint_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gie_i,
  input logic       src_en_i,
  input logic       flag_clr_i,
  input logic       retire_i,
  input logic       pending_o,
  input logic       wake_o,
  input logic       vector_o,
  input logic       sync_edge,
  input logic       set_evt,
  input logic       pin_s,
  input logic       rise_q,
  input logic       sleeping,
  input logic       in_hold,
  input seq_state_t state_q
);
  AST_EDGE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_edge |-> (rise_q ? pin_s : !pin_s)); // R2
  AST_EVENT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> pending_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !flag_clr_i) |=> pending_o); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !set_evt) |=> !pending_o); // R4
  AST_VECTOR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> (pending_o && $past(gie_i) && $past(src_en_i))); // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hold |-> !vector_o); // R9
  AST_WAKE_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleeping); // R7
  AST_RETIRE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && retire_i) |=> !in_hold); // R9
endmodule

bind extint_wake_ctrl extint_wake_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gie_i     (gie_i),
  .src_en_i  (src_en_i),
  .flag_clr_i(flag_clr_i),
  .retire_i  (retire_i),
  .pending_o (pending_o),
  .wake_o    (wake_o),
  .vector_o  (vector_o),
  .sync_edge (sync_edge),
  .set_evt   (set_evt),
  .pin_s     (pin_s),
  .rise_q    (rise_q),
  .sleeping  (sleeping),
  .in_hold   (in_hold),
  .state_q   (state_q)
);

// File: tb/test_extint_wake_ctrl.sv
`timescale 1ns/1ps
module test_extint_wake_ctrl;
  logic clk = 1'b0;
  logic run_clk = 1'b1;
  logic rst_n = 1'b0;
  logic pin = 1'b0, rise = 1'b1, en = 1'b0, gie = 1'b0;
  logic slp = 1'b0, clr = 1'b0, ret = 1'b0;
  logic pending, wake, vector;
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    when;
    int    sel;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  extint_wake_ctrl i_extint_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .int_pin_i(pin), .edge_rise_i(rise),
    .src_en_i(en), .gie_i(gie), .sleep_i(slp), .flag_clr_i(clr),
    .retire_i(ret), .pending_o(pending), .wake_o(wake), .vector_o(vector)
  );

  initial forever begin
    #4;
    if (run_clk) clk = ~clk;
  end

  always @(posedge clk) cyc++;

  // monitor: pops expectations that are due and compares them
  always @(negedge clk) begin : mon
    exp_t e;
    logic act;
    while (sb.size() > 0 && sb[0].when <= cyc) begin
      e = sb.pop_front();
      act = (e.sel == 0) ? pending : (e.sel == 1) ? wake : vector;
      total++;
      if (act !== e.val) begin
        bad++;
        $display("FAIL %s cyc=%0d sel=%0d actual=%b expected=%b",
                 e.tag, cyc, e.sel, act, e.val);
      end
    end
  end

  task automatic push(int dly, int sel, logic val, string tag);
    exp_t e;
    e.when = cyc + dly; e.sel = sel; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(string tag, logic act, logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(1); clr = 1'b0; step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 pending", pending, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R1 vector", vector, 1'b0);

    // rising edge, enables off: flag still latches
    pin = 1'b1;
    push(2, 0, 1'b0, "R3 early"); push(3, 0, 1'b1, "R3 latch");
    push(3, 2, 1'b0, "R6 no enables");
    step(4);
    clr = 1'b1; push(1, 0, 1'b0, "R4 clear"); step(1); clr = 1'b0; step(1);
    // falling edge ignored with rising selected
    pin = 1'b0; push(4, 0, 1'b0, "R2 fall ignored"); step(5);
    // falling polarity
    rise = 1'b0; step(2);
    pin = 1'b1; push(4, 0, 1'b0, "R2 rise ignored"); step(5);
    pin = 1'b0; push(3, 0, 1'b1, "R2 fall valid"); step(4);
    clear_flag();
    rise = 1'b1; step(2);
    // set and clear on the same edge
    pin = 1'b1; step(2);
    clr = 1'b1; push(1, 0, 1'b1, "R5 set wins"); step(1);
    clr = 1'b0; push(1, 0, 1'b1, "R4 stays"); step(2);
    // vector gating
    en = 1'b1; push(2, 2, 1'b0, "R6 gie off"); step(2);
    gie = 1'b1; push(1, 2, 1'b1, "R6 all set"); step(2);
    en = 1'b0; push(1, 2, 1'b0, "R6 en off"); step(2);
    en = 1'b1; push(1, 2, 1'b1, "R6 en back"); step(2);
    clr = 1'b1; push(1, 2, 1'b0, "R6 flag off"); step(1); clr = 1'b0;
    gie = 1'b0; step(2);
    // sleep with the clock stopped
    pin = 1'b0; step(4);
    slp = 1'b1; push(1, 1, 1'b0, "R7 nothing yet"); step(3);
    run_clk = 1'b0;
    #20;
    chk("R7 idle asleep", wake, 1'b0);
    pin = 1'b1;
    #5;
    chk("R7 async wake", wake, 1'b1);
    #20;
    run_clk = 1'b1;
    step(1);
    push(2, 0, 1'b1, "R7 flag after restart"); push(2, 1, 1'b1, "R7 wake held");
    step(3);
    slp = 1'b0; push(1, 1, 1'b0, "R10 wake drop"); step(2);
    ret = 1'b1; step(1); ret = 1'b0;
    push(1, 2, 1'b0, "R9 no gie no vector"); step(2);
    clear_flag();
    // enable raised after sleep entry
    en = 1'b0; step(2);
    slp = 1'b1; step(2);
    en = 1'b1; step(2);
    pin = 1'b0; step(4);
    pin = 1'b1;
    push(3, 0, 1'b1, "R8 flag sets"); push(3, 1, 1'b0, "R8 no wake");
    push(5, 1, 1'b0, "R8 still no wake");
    step(6);
    slp = 1'b0; step(2);
    ret = 1'b1; step(1); ret = 1'b0;
    clear_flag();
    // wake with global enable: branch waits for retire
    gie = 1'b1; pin = 1'b0; step(4);
    slp = 1'b1; step(2);
    pin = 1'b1;
    push(1, 1, 1'b1, "R7 wake"); push(3, 0, 1'b1, "R3 asleep");
    push(3, 2, 1'b0, "R9 asleep no vector");
    step(4);
    slp = 1'b0; push(1, 1, 1'b0, "R10 drop"); push(1, 2, 1'b0, "R9 held");
    step(3);
    ret = 1'b1; push(1, 2, 1'b1, "R9 after retire"); step(1); ret = 1'b0;
    step(2);
    // already pending at sleep entry
    gie = 1'b0; step(2);
    slp = 1'b1; push(1, 1, 1'b1, "R7 pending at entry"); step(2);
    slp = 1'b0; step(2);
    ret = 1'b1; step(1); ret = 1'b0;
    step(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule